// File: doc/BRIEF.md
# FFT Result Dump Controller

This block sequences the output side of a transform engine. Once a transform finishes, it counts a fixed number of output-strobe pulses to prime the output pipeline. Only then does it raise the active-low data-available flag. It then steps the result read address upward from bin 0, one bin per accepted strobe, and drops the flag on the strobe that moves the final bin.

Whether dump enable is low at transform completion sets how the dump starts. If it is low, data-available turns on at the priming strobe itself and dumping runs on its own. If it is high, the block waits for dump enable to fall. A configuration input adds 24 more strobes of delay before data-available. This matches the latency of a downstream magnitude/phase stage.

The real and imaginary output buses are driven only while data-available and dump enable are both active. Otherwise they float. The scale tag captured with the transform is presented throughout. A transform that reported overflow dumps all-zero values. Everything runs on one clock, and the output strobe is a single-cycle pulse.

Top module: `fft_dump_ctrl`

## Requirements
- R1: After reset, `dav_n` is 1, `out_en` is 0 and `rd_addr` is 0.
- R2: After `xform_done`, `dav_n` stays 1 until two strobe pulses have been seen. When `dump_en_n` was 0 at completion, `dav_n` becomes 0 on the clock edge of the second priming strobe.
- R3: When `dump_en_n` was 1 at completion, `dav_n` stays 1 after priming until `dump_en_n` is seen low. It then becomes 0 on the next clock edge.
- R4: While `dav_n` is 0, the first accepted strobe (strobe with `dump_en_n` low) transfers bin 0. Each later accepted strobe transfers the next bin in ascending order.
- R5: The accepted strobe that transfers bin NBINS-1 returns `dav_n` to 1 and `rd_addr` to 0 on that edge.
- R6: `out_en` is 1 exactly when `dav_n` and `dump_en_n` are both 0. The buses carry data only then and are high impedance otherwise.
- R7: If `delay_en` is 1 at completion, `dav_n` goes low only after 24 further strobes beyond the two priming strobes.
- R8: A strobe with `dump_en_n` high during a dump does not advance `rd_addr`.
- R9: If `xform_ovf` is 1 at completion, every enabled bus value of that dump is zero.
- R10: `scale_out` shows the `scale_in` value captured at completion and holds it through the dump.
- R11: An `xform_done` pulse that arrives while a completion is already being primed, delayed or dumped is ignored. This includes the cycle of the last transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xform_done | input | 1 | One-cycle pulse: transform finished |
| xform_ovf | input | 1 | Overflow flag of the finished transform |
| scale_in | input | SCALE_W | Scale tag of the finished transform |
| delay_en | input | 1 | Add 24-strobe delay before data-available |
| strobe | input | 1 | Output strobe pulse |
| dump_en_n | input | 1 | Active-low dump enable |
| rd_re | input | DATA_W | Real value read at `rd_addr` |
| rd_im | input | DATA_W | Imaginary value read at `rd_addr` |
| rd_addr | output | ADDR_W | Result bin address |
| dav_n | output | 1 | Active-low data available |
| out_en | output | 1 | Bus drive enable |
| re_bus | output | DATA_W | Real output bus, tri-stated |
| im_bus | output | DATA_W | Imaginary output bus, tri-stated |
| scale_out | output | SCALE_W | Scale tag of the results being dumped |

## Verification
Two cases meet in a single cycle. In the first, a new transform completion arrives on the same edge as the strobe that moves the final bin. The bench pulses `xform_done` together with that last strobe, then checks three things: `dav_n` returns high, it stays high through later strobes, and no new scale tag is captured.

In the second, dump enable goes high on the same cycle as a strobe. The bench checks that the address holds and the bus enable falls. After release, it checks that the dump resumes at the held bin.

// File: rtl/fft_dump_pkg.sv
package fft_dump_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PRIME = 3'd1,
    ST_DELAY = 3'd2,
    ST_WAIT  = 3'd3,
    ST_DUMP  = 3'd4
  } dump_st_e;
endpackage

// File: rtl/dump_seq.sv
module dump_seq
  import fft_dump_pkg::*;
#(
  parameter int PRIME_N = 2,
  parameter int DLY_N   = 24
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     xform_done,
  input  logic     strobe,
  input  logic     dump_en_n,
  input  logic     delay_en,
  input  logic     last_xfer,
  output dump_st_e st
);
  localparam int CMAX  = (PRIME_N > DLY_N) ? PRIME_N : DLY_N;
  localparam int CNT_W = $clog2(CMAX + 1);
  localparam logic [CNT_W-1:0] PRIME_LAST = CNT_W'(PRIME_N - 1);
  localparam logic [CNT_W-1:0] DLY_LAST   = CNT_W'(DLY_N - 1);

  dump_st_e         st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             auto_q, auto_d;
  logic             dly_q, dly_d;

  // after priming or delay: auto mode dumps at once, else waits for enable
  dump_st_e ready_st;
  assign ready_st = auto_q ? ST_DUMP : ST_WAIT;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    auto_d = auto_q;
    dly_d  = dly_q;
    unique case (st_q)
      ST_IDLE: begin
        if (xform_done) begin
          st_d   = ST_PRIME;
          cnt_d  = '0;
          auto_d = ~dump_en_n;
          dly_d  = delay_en;
        end
      end
      ST_PRIME: begin
        if (strobe) begin
          if (cnt_q == PRIME_LAST) begin
            cnt_d = '0;
            st_d  = dly_q ? ST_DELAY : ready_st;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      ST_DELAY: begin
        if (strobe) begin
          if (cnt_q == DLY_LAST) begin
            cnt_d = '0;
            st_d  = ready_st;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      ST_WAIT: begin
        if (!dump_en_n) st_d = ST_DUMP;
      end
      ST_DUMP: begin
        if (last_xfer) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      auto_q <= 1'b0;
      dly_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      auto_q <= auto_d;
      dly_q  <= dly_d;
    end
  end

  assign st = st_q;
endmodule

// File: rtl/dump_addr.sv
module dump_addr #(
  parameter int NBINS = 256
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     xfer,
  output logic [$clog2(NBINS)-1:0] addr,
  output logic                     last
);
  localparam int ADDR_W = $clog2(NBINS);
  localparam logic [ADDR_W-1:0] LAST_BIN = ADDR_W'(NBINS - 1);

  logic [ADDR_W-1:0] addr_q, addr_d;

  assign last = (addr_q == LAST_BIN);

  always_comb begin
    addr_d = addr_q;
    if (xfer) addr_d = last ? '0 : addr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end

  assign addr = addr_q;
endmodule

// File: rtl/fft_dump_ctrl.sv
module fft_dump_ctrl
  import fft_dump_pkg::*;
#(
  parameter int NBINS   = 256,
  parameter int DATA_W  = 16,
  parameter int SCALE_W = 4,
  parameter int PRIME_N = 2,
  parameter int DLY_N   = 24,
  localparam int ADDR_W = $clog2(NBINS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               xform_done,
  input  logic               xform_ovf,
  input  logic [SCALE_W-1:0] scale_in,
  input  logic               delay_en,
  input  logic               strobe,
  input  logic               dump_en_n,
  input  logic [DATA_W-1:0]  rd_re,
  input  logic [DATA_W-1:0]  rd_im,
  output logic [ADDR_W-1:0]  rd_addr,
  output logic               dav_n,
  output logic               out_en,
  output logic [DATA_W-1:0]  re_bus,
  output logic [DATA_W-1:0]  im_bus,
  output logic [SCALE_W-1:0] scale_out
);
  dump_st_e st;
  logic     accept;
  logic     dumping;
  logic     xfer;
  logic     last_bin;

  logic               ovf_q, ovf_d;
  logic [SCALE_W-1:0] scale_q, scale_d;

  dump_seq #(.PRIME_N(PRIME_N), .DLY_N(DLY_N)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .xform_done(xform_done),
    .strobe    (strobe),
    .dump_en_n (dump_en_n),
    .delay_en  (delay_en),
    .last_xfer (xfer & last_bin),
    .st        (st)
  );

  assign dumping = (st == ST_DUMP);
  assign xfer    = dumping & strobe & ~dump_en_n;

  dump_addr #(.NBINS(NBINS)) u_addr (
    .clk  (clk),
    .rst_n(rst_n),
    .xfer (xfer),
    .addr (rd_addr),
    .last (last_bin)
  );

  // capture per-transform attributes only when the sequencer accepts
  assign accept = xform_done & (st == ST_IDLE);

  always_comb begin
    ovf_d   = ovf_q;
    scale_d = scale_q;
    if (accept) begin
      ovf_d   = xform_ovf;
      scale_d = scale_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q   <= 1'b0;
      scale_q <= '0;
    end else begin
      ovf_q   <= ovf_d;
      scale_q <= scale_d;
    end
  end

  logic [DATA_W-1:0] re_val, im_val;
  assign re_val = ovf_q ? '0 : rd_re;
  assign im_val = ovf_q ? '0 : rd_im;

  assign dav_n     = ~dumping;
  assign out_en    = dumping & ~dump_en_n;
  assign re_bus    = out_en ? re_val : 'z;
  assign im_bus    = out_en ? im_val : 'z;
  assign scale_out = scale_q;
endmodule

// File: rtl/dump_ctrl_chk.sv
module dump_ctrl_chk #(
  parameter int NBINS   = 256,
  parameter int SCALE_W = 4,
  localparam int ADDR_W = $clog2(NBINS)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               strobe,
  input logic               dump_en_n,
  input logic [ADDR_W-1:0]  rd_addr,
  input logic               dav_n,
  input logic [SCALE_W-1:0] scale_out
);
  localparam logic [ADDR_W-1:0] LAST_BIN = ADDR_W'(NBINS - 1);

  // R1: a nonzero address exists only inside a dump
  a_r1_addr_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr != '0) |-> !dav_n);

  // R4: each accepted strobe before the last bin steps the address by one
  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!dav_n && strobe && !dump_en_n && rd_addr != LAST_BIN)
      |=> (rd_addr == $past(rd_addr) + 1'b1) && !dav_n);

  // R5: the transfer of the last bin ends the dump
  a_r5_last: assert property (@(posedge clk) disable iff (!rst_n)
    (!dav_n && strobe && !dump_en_n && rd_addr == LAST_BIN)
      |=> dav_n && (rd_addr == '0));

  // R8: no address change without an accepted strobe
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!dav_n && !(strobe && !dump_en_n)) |=> $stable(rd_addr));

  // R10: scale tag steady while results are available
  a_r10_scale: assert property (@(posedge clk) disable iff (!rst_n)
    (!dav_n && $past(!dav_n)) |-> $stable(scale_out));
endmodule

bind fft_dump_ctrl dump_ctrl_chk #(.NBINS(NBINS), .SCALE_W(SCALE_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .strobe   (strobe),
  .dump_en_n(dump_en_n),
  .rd_addr  (rd_addr),
  .dav_n    (dav_n),
  .scale_out(scale_out)
);

// File: tb/test_fft_dump_ctrl.sv
module test_fft_dump_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NBINS  = 256;
  localparam int DATA_W = 16;
  localparam int SCALE_W = 4;
  localparam int ADDR_W = $clog2(NBINS);

  logic clk = 1'b0;
  logic rst_n;
  logic xform_done, xform_ovf, delay_en, strobe, dump_en_n;
  logic [SCALE_W-1:0] scale_in;
  logic [DATA_W-1:0]  rd_re, rd_im;
  logic [ADDR_W-1:0]  rd_addr;
  logic               dav_n, out_en;
  logic [DATA_W-1:0]  re_bus, im_bus;
  logic [SCALE_W-1:0] scale_out;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // result memory model: value is a function of the bin
  assign rd_re = DATA_W'(rd_addr) * 16'd3 + 16'd256;
  assign rd_im = ~(DATA_W'(rd_addr) * 16'd5);

  function automatic logic [DATA_W-1:0] exp_re(int k);
    return DATA_W'(k) * 16'd3 + 16'd256;
  endfunction
  function automatic logic [DATA_W-1:0] exp_im(int k);
    return ~(DATA_W'(k) * 16'd5);
  endfunction

  fft_dump_ctrl #(.NBINS(NBINS), .DATA_W(DATA_W), .SCALE_W(SCALE_W)) i_fft_dump_ctrl (
    .clk(clk), .rst_n(rst_n), .xform_done(xform_done), .xform_ovf(xform_ovf),
    .scale_in(scale_in), .delay_en(delay_en), .strobe(strobe), .dump_en_n(dump_en_n),
    .rd_re(rd_re), .rd_im(rd_im), .rd_addr(rd_addr), .dav_n(dav_n), .out_en(out_en),
    .re_bus(re_bus), .im_bus(im_bus), .scale_out(scale_out)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic pulse_strobe();
    strobe = 1'b1;
    tick();
    strobe = 1'b0;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic start(logic den_n, logic ovf, logic [SCALE_W-1:0] sc, logic dly);
    dump_en_n  = den_n;
    xform_ovf  = ovf;
    scale_in   = sc;
    delay_en   = dly;
    xform_done = 1'b1;
    tick();
    xform_done = 1'b0;
    xform_ovf  = 1'b0;
    delay_en   = 1'b0;
  endtask

  // transfer bins from..NBINS-1, checking each before its strobe
  task automatic dump_bins(int from, logic ovf, logic [SCALE_W-1:0] sc);
    for (int k = from; k < NBINS; k++) begin
      if (k < 3 || k == NBINS - 1 || k % 37 == 0) begin
        check("R4 addr", 32'(rd_addr), 32'(k));
        check("R6 out_en", 32'(out_en), 32'd1);
        check(ovf ? "R9 re zero" : "R4 re", 32'(re_bus), ovf ? 32'd0 : 32'(exp_re(k)));
        check(ovf ? "R9 im zero" : "R4 im", 32'(im_bus), ovf ? 32'd0 : 32'(exp_im(k)));
        check("R10 scale", 32'(scale_out), 32'(sc));
      end
      if (k % 11 == 5) tick();
      pulse_strobe();
    end
    check("R5 dav_n after last", 32'(dav_n), 32'd1);
    check("R5 addr wraps", 32'(rd_addr), 32'd0);
    check("R6 out_en idle", 32'(out_en), 32'd0);
  endtask

  task automatic t_reset();
    check("R1 dav_n", 32'(dav_n), 32'd1);
    check("R1 out_en", 32'(out_en), 32'd0);
    check("R1 addr", 32'(rd_addr), 32'd0);
  endtask

  task automatic t_auto();
    start(1'b0, 1'b0, 4'd6, 1'b0);
    tick(); tick();
    check("R2 no dav before priming", 32'(dav_n), 32'd1);
    pulse_strobe();
    check("R2 dav after one strobe", 32'(dav_n), 32'd1);
    tick();
    pulse_strobe();
    check("R2 dav on second strobe", 32'(dav_n), 32'd0);
    dump_bins(0, 1'b0, 4'd6);
  endtask

  task automatic t_manual();
    start(1'b1, 1'b0, 4'd9, 1'b0);
    pulse_strobe();
    pulse_strobe();
    repeat (4) tick();
    check("R3 waits for enable", 32'(dav_n), 32'd1);
    check("R6 bus floats", 32'(out_en), 32'd0);
    dump_en_n = 1'b0;
    tick();
    check("R3 dav after enable", 32'(dav_n), 32'd0);
    dump_bins(0, 1'b0, 4'd9);
  endtask

  task automatic t_delay();
    start(1'b0, 1'b0, 4'd2, 1'b1);
    for (int i = 0; i < 25; i++) pulse_strobe();
    check("R7 dav still high after 25", 32'(dav_n), 32'd1);
    pulse_strobe();
    check("R7 dav low after 26", 32'(dav_n), 32'd0);
    dump_bins(0, 1'b0, 4'd2);
  endtask

  task automatic t_pause();
    start(1'b0, 1'b0, 4'd11, 1'b0);
    pulse_strobe();
    pulse_strobe();
    for (int k = 0; k < 5; k++) pulse_strobe();
    dump_en_n = 1'b1;
    strobe = 1'b1;          // strobe in same cycle enable rises
    tick();
    strobe = 1'b0;
    pulse_strobe();
    pulse_strobe();
    check("R8 addr held", 32'(rd_addr), 32'd5);
    check("R6 out_en low while paused", 32'(out_en), 32'd0);
    check("R8 dav kept", 32'(dav_n), 32'd0);
    dump_en_n = 1'b0;
    #1;
    check("R6 out_en back", 32'(out_en), 32'd1);
    dump_bins(5, 1'b0, 4'd11);
  endtask

  task automatic t_ovf();
    start(1'b0, 1'b1, 4'd15, 1'b0);
    pulse_strobe();
    pulse_strobe();
    dump_bins(0, 1'b1, 4'd15);
  endtask

  task automatic t_ignore_done();
    start(1'b0, 1'b0, 4'd3, 1'b0);
    pulse_strobe();
    scale_in = 4'd12;
    xform_done = 1'b1;       // during priming
    tick();
    xform_done = 1'b0;
    pulse_strobe();
    check("R11 scale kept", 32'(scale_out), 32'd3);
    for (int k = 0; k < NBINS - 1; k++) pulse_strobe();
    xform_ovf  = 1'b1;
    xform_done = 1'b1;       // same cycle as last transfer
    strobe     = 1'b1;
    tick();
    strobe     = 1'b0;
    xform_done = 1'b0;
    xform_ovf  = 1'b0;
    check("R11 dav off after last", 32'(dav_n), 32'd1);
    pulse_strobe();
    pulse_strobe();
    pulse_strobe();
    check("R11 no restart", 32'(dav_n), 32'd1);
    check("R11 scale not recaptured", 32'(scale_out), 32'd3);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    xform_done = 1'b0; xform_ovf = 1'b0; delay_en = 1'b0;
    strobe = 1'b0; dump_en_n = 1'b0; scale_in = '0;
    repeat (3) tick();
    t_reset();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_auto();
    t_manual();
    t_delay();
    t_pause();
    t_ovf();
    t_ignore_done();
    finish_run();
  end
endmodule